// File: doc/BRIEF.md
# Video Resolution Mode Register

This block holds the two-bit resolution mode of a video shifter and makes it reachable from the system bus in both directions. Firmware writes a byte into the register with a chip select and a read/not-write line. Only the low two bits are kept. A read with the same select returns the stored mode in the low two bits, and every bit above them reads as one. Firmware therefore masks the value it gets back with 3.

The stored mode does not reach the video path straight away. A separate display copy feeds the scanline doubler, and it is reloaded only on a frame-start pulse, so a change of mode never splits a frame. The pattern 3 is kept and read back exactly as written. The video path treats it as high resolution.

The bus is modelled with three ports: a separate input data port, an output data port and an output enable. A pad ring turns these into a tri-state byte.

Top module: `vmode_reg`

## Requirements
- R1: Synchronous active-high reset. After reset the stored mode and the exported mode are both 0 (low resolution), and a read returns 8'hFC.
- R2: In a cycle with `bus_cs`=1 and `bus_rnw`=0, the register takes `bus_din[1:0]` at that clock edge. `bus_din[7:2]` is discarded.
- R3: While `bus_cs`=1 and `bus_rnw`=1, in the same cycle, `bus_oe`=1 and `bus_dout` equals {6'b111111, stored mode}.
- R4: Whenever a read is not in progress, `bus_oe`=0 and `bus_dout`=8'h00.
- R5: The stored mode is left unchanged in any cycle without a write. This includes cycles with `bus_cs`=0 and any data on `bus_din`, and read cycles.
- R6: The value 3 is stored and read back as 8'hFF. It is exported as 2 (high resolution), so `mode_out` never shows 3.
- R7: `mode_out` changes only at a clock edge where `frame_start`=1. At that edge it loads the mode that was stored before the edge. A write in the same cycle as `frame_start` shows only at the next frame start.
- R8: The mode encodings 0 (low), 1 (medium) and 2 (high, monochrome) are passed to `mode_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Register select |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_din | input | 8 | Write data from the bus |
| bus_dout | output | 8 | Read data to the bus |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| mode_out | output | 2 | Resolution mode for the scanline doubler |

## Verification
Each of the four mode values is written and then read back. This checks that the low bits are stored, that the upper bits read as ones, and that 3 is exported as 2 while it reads back as 3. Writes with junk in the upper data bits, with select low, and during a read show that only a true write cycle with the low two bits changes state. Writes are placed before frame pulses, between them and in the same cycle as a pulse. These cases separate a display copy that is loaded at the frame edge from one that follows the register directly.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

    localparam int MODE_W = 2;

    typedef logic [MODE_W-1:0] mode_t;

    typedef enum logic [MODE_W-1:0] {
        RES_LOW  = 2'd0,
        RES_MED  = 2'd1,
        RES_HIGH = 2'd2,
        RES_RSVD = 2'd3
    } res_mode_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        mode_t wdata;
    } bus_req_t;

    // Reserved pattern is shown to the video path as high resolution.
    function automatic mode_t to_display(mode_t raw);
        if (raw == mode_t'(RES_RSVD))
            return mode_t'(RES_HIGH);
        return raw;
    endfunction

endpackage

// File: rtl/vmode_bus_decode.sv
module vmode_bus_decode
    import vmode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              bus_cs,
    input  logic              bus_rnw,
    input  logic [DATA_W-1:0] bus_din,
    output bus_req_t          req
);
    logic unused_din_hi;
    assign unused_din_hi = ^bus_din[DATA_W-1:MODE_W];

    always_comb begin
        req.wr    = bus_cs & ~bus_rnw;
        req.rd    = bus_cs &  bus_rnw;
        req.wdata = bus_din[MODE_W-1:0];
    end
endmodule

// File: rtl/vmode_store.sv
module vmode_store
    import vmode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output mode_t    stored
);
    always_ff @(posedge clk) begin
        if (rst)
            stored <= mode_t'(RES_LOW);
        else if (req.wr)
            stored <= req.wdata;
    end

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        req.wr |=> stored == $past(req.wdata)); // R2
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !req.wr |=> $stable(stored)); // R5
endmodule

// File: rtl/vmode_readback.sv
module vmode_readback
    import vmode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  mode_t             stored,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe
);
    localparam int HI_W = DATA_W - MODE_W;

    always_comb begin
        bus_oe   = req.rd;
        bus_dout = '0;
        if (req.rd)
            bus_dout = {{HI_W{1'b1}}, stored};
    end

    AST_READ_UPPER_ONES: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> &bus_dout[DATA_W-1:MODE_W]); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> bus_dout == '0); // R4
endmodule

// File: rtl/vmode_frame_latch.sv
module vmode_frame_latch
    import vmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_start,
    input  mode_t stored,
    output mode_t mode_out
);
    always_ff @(posedge clk) begin
        if (rst)
            mode_out <= mode_t'(RES_LOW);
        else if (frame_start)
            mode_out <= to_display(stored);
    end

    AST_EXPORT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(mode_out)); // R7
    AST_EXPORT_LOAD: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> mode_out == to_display($past(stored))); // R7
    AST_EXPORT_NO_RSVD: assert property (@(posedge clk) disable iff (rst)
        mode_out != mode_t'(RES_RSVD)); // R6
endmodule

// File: rtl/vmode_reg.sv
module vmode_reg
    import vmode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs,
    input  logic              bus_rnw,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic              frame_start,
    output logic [MODE_W-1:0] mode_out
);
    bus_req_t req;
    mode_t    stored;

    vmode_bus_decode #(.DATA_W(DATA_W)) u_decode (
        .bus_cs  (bus_cs),
        .bus_rnw (bus_rnw),
        .bus_din (bus_din),
        .req     (req)
    );

    vmode_store u_store (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .stored (stored)
    );

    vmode_readback #(.DATA_W(DATA_W)) u_readback (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .stored   (stored),
        .bus_dout (bus_dout),
        .bus_oe   (bus_oe)
    );

    vmode_frame_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .stored      (stored),
        .mode_out    (mode_out)
    );

    AST_READ_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && bus_rnw) |-> bus_oe); // R3
    AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
        !bus_cs |-> !bus_oe); // R4
endmodule

// File: tb/vmode_reg_tb.sv
module vmode_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cs = 1'b0;
    logic       bus_rnw = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic       frame_start = 1'b0;
    logic [1:0] mode_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vmode_reg dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_cs      (bus_cs),
        .bus_rnw     (bus_rnw),
        .bus_din     (bus_din),
        .bus_dout    (bus_dout),
        .bus_oe      (bus_oe),
        .frame_start (frame_start),
        .mode_out    (mode_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] v);
        @(negedge clk);
        bus_cs = 1'b1; bus_rnw = 1'b0; bus_din = v;
        @(negedge clk);
        bus_cs = 1'b0; bus_din = 8'h00;
    endtask

    task automatic bus_read(output logic [7:0] d, output logic oe);
        @(negedge clk);
        bus_cs = 1'b1; bus_rnw = 1'b1;
        #1;
        d = bus_dout; oe = bus_oe;
        @(negedge clk);
        bus_cs = 1'b0; bus_rnw = 1'b0;
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 mode_out after reset", mode_out, 0);
        check("R4 oe idle after reset", bus_oe, 0);
        bus_read(d, oe);
        check("R1 readback after reset", d, 8'hFC);
        check("R3 oe during read", oe, 1);
    endtask

    task automatic t_encodings();
        logic [7:0] d; logic oe;
        for (int m = 0; m < 3; m++) begin
            bus_write(8'(m));
            bus_read(d, oe);
            check("R2 readback of written mode", d, 8'hFC | m);
            frame_pulse();
            check("R8 exported encoding", mode_out, m);
        end
    endtask

    task automatic t_reserved();
        logic [7:0] d; logic oe;
        bus_write(8'h03);
        bus_read(d, oe);
        check("R6 reserved reads back", d, 8'hFF);
        frame_pulse();
        check("R6 reserved exported as high", mode_out, 2);
    endtask

    task automatic t_upper_bits();
        logic [7:0] d; logic oe;
        bus_write(8'h01);
        bus_write(8'h00 | 8'hA8);   // low bits 0, upper junk
        bus_read(d, oe);
        check("R2 upper write bits dropped", d, 8'hFC);
        bus_write(8'h55);           // low bits 1
        bus_read(d, oe);
        check("R2 low bits of junk byte", d, 8'hFD);
    endtask

    task automatic t_ignored();
        logic [7:0] d; logic oe;
        bus_write(8'h02);
        @(negedge clk);
        bus_cs = 1'b0; bus_rnw = 1'b0; bus_din = 8'h01;
        @(negedge clk);
        bus_din = 8'h00;
        bus_read(d, oe);
        check("R5 unselected write ignored", d, 8'hFE);
        @(negedge clk);
        bus_cs = 1'b1; bus_rnw = 1'b1; bus_din = 8'h01;
        #1;
        check("R3 read data during read with din", bus_dout, 8'hFE);
        @(negedge clk);
        bus_cs = 1'b0; bus_rnw = 1'b0; bus_din = 8'h00;
        bus_read(d, oe);
        check("R5 read cycle does not write", d, 8'hFE);
        #1;
        check("R4 oe low after read", bus_oe, 0);
        check("R4 dout zero after read", bus_dout, 0);
    endtask

    task automatic t_frame_timing();
        frame_pulse();
        check("R7 export loaded at frame", mode_out, 2);
        bus_write(8'h01);
        repeat (4) @(negedge clk);
        #1;
        check("R7 export held between frames", mode_out, 2);
        // write coincident with frame pulse
        @(negedge clk);
        bus_cs = 1'b1; bus_rnw = 1'b0; bus_din = 8'h00; frame_start = 1'b1;
        @(negedge clk);
        bus_cs = 1'b0; frame_start = 1'b0;
        #1;
        check("R7 coincident frame takes prior value", mode_out, 1);
        frame_pulse();
        check("R7 next frame takes new value", mode_out, 0);
    endtask

    initial begin
        t_reset();
        t_encodings();
        t_reserved();
        t_upper_bits();
        t_ignored();
        t_frame_timing();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule